// File: doc/BRIEF.md
# Shared Under-Load Delay Timer

This block decides when a light-load condition on a bank of switches has lasted long enough to be reported. Each switch has a comparator flag that rises when its current falls under the minimum expected load, and a commanded-on bit from the control register. A channel counts as offending only while it is commanded on, its flag is raised, and it has not already been latched off.

Every channel shares one delay counter. The counter starts when the first channel begins to offend. It keeps running while any channel is still offending, and it returns to idle as soon as none is. When the counter expires, a sticky status bit is set. If the shutdown-enable input is high, every channel that is offending at that moment is also latched off. A channel that starts offending after the counter has started does not get a delay of its own. It is flagged at the same expiry, so its effective delay is only the time that was left.

The status bit and the latch-off mask are cleared only by the status-reset strobe. The control logic raises that strobe for one cycle after it accepts a valid command frame with the reset bit set. The delay is a parameter counted in clock cycles.

Top module: `underload_timer`

## Requirements
- R1: After synchronous reset, `ul_status` is 0 and `latch_off` is all zeros.
- R2: If one channel offends continuously, `ul_status` rises after exactly DELAY_CYC rising clock edges of offending, and not one edge earlier.
- R3: If the offending condition ends before expiry, the counter goes idle. A later offending episode then needs the full DELAY_CYC edges again.
- R4: A raised flag on a channel whose `sw_on` bit is 0 has no effect on `ul_status`, on `latch_off` or on the counter.
- R5: A channel that starts offending while the counter is running is reported at the expiry that is already in progress.
- R6: When `shut_en` is 1 at expiry, `latch_off` gains the bits of the channels that are offending at that moment. When `shut_en` is 0, `latch_off` does not change, but `ul_status` is still set.
- R7: `ul_status` and `latch_off` hold their values after the flags clear, until `stat_clr` is raised.
- R8: A one-cycle `stat_clr` pulse clears `ul_status` and `latch_off` and restarts the counter from zero. A condition that is still present is reported again after DELAY_CYC further edges.
- R9: Channels whose flag is low at expiry, and channels that are commanded off, are never placed in `latch_off`.
- R10: A channel in `latch_off` no longer counts as offending. A new offending channel after a shutdown therefore waits the full DELAY_CYC from an idle counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ul_flag | input | NUM_CH | Per-channel light-load comparator flags (bit i = channel i) |
| sw_on | input | NUM_CH | Per-channel commanded-on state (bit i = channel i) |
| shut_en | input | 1 | 1 = latch offending channels off at expiry |
| stat_clr | input | 1 | One-cycle status-reset strobe from an accepted frame |
| ul_status | output | 1 | Sticky light-load fault indication |
| latch_off | output | NUM_CH | Channels forced off by light-load shutdown |

## Verification
The hardest case to reach is a second channel that starts offending part-way through a delay. It must be latched at the first channel's expiry, not one full delay after its own start. The stimulus raises channel 2 and then, ten edges later, channel 7. It checks that the mask is still empty one edge before the first channel's expiry and that it holds both channels one edge later. A second hard case follows a shutdown. The latched channels keep their flags raised while a new channel starts offending. The bench counts a full fresh delay for the new channel, which shows that the latched channels stopped feeding the counter.

// File: rtl/ulg_pkg.sv
package ulg_pkg;

    localparam int CH_DEFAULT    = 12;
    localparam int DELAY_DEFAULT = 20;

    typedef enum logic {
        T_IDLE = 1'b0,
        T_RUN  = 1'b1
    } tmr_state_e;

    typedef struct packed {
        logic active;
        logic expire;
    } tmr_evt_t;

endpackage

// File: rtl/ulg_qualify.sv
module ulg_qualify #(
    parameter int NUM_CH = ulg_pkg::CH_DEFAULT
) (
    input  logic [NUM_CH-1:0] ul_flag,
    input  logic [NUM_CH-1:0] sw_on,
    input  logic [NUM_CH-1:0] latched,
    output logic [NUM_CH-1:0] offend,
    output logic              any_offend
);

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        assign offend[i] = ul_flag[i] & sw_on[i] & ~latched[i];
    end

    assign any_offend = |offend;

endmodule

// File: rtl/ulg_timer.sv
module ulg_timer
    import ulg_pkg::*;
#(
    parameter int DELAY_CYC = ulg_pkg::DELAY_DEFAULT
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     any_offend,
    output tmr_evt_t evt
);

    localparam int CW = (DELAY_CYC > 2) ? $clog2(DELAY_CYC) : 1;
    localparam logic [CW-1:0] LAST = CW'(DELAY_CYC - 1);

    tmr_state_e    st;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || restart || !any_offend) begin
            st  <= T_IDLE;
            cnt <= '0;
        end else if (cnt == LAST) begin
            st  <= T_RUN;
            cnt <= '0;
        end else begin
            st  <= T_RUN;
            cnt <= cnt + 1'b1;
        end
    end

    assign evt.active = any_offend;
    assign evt.expire = any_offend && (cnt == LAST) && (st == T_RUN || DELAY_CYC == 1);

    // R2: the counter never passes its terminal value
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    // R3: with nothing offending, the counter is back at zero on the next edge
    a_r3_idle_reset: assert property (@(posedge clk) disable iff (rst)
        (!any_offend) |=> (cnt == '0 && st == T_IDLE));

    // R8: a restart returns the counter to zero
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
        restart |=> (cnt == '0));

endmodule

// File: rtl/ulg_latch.sv
module ulg_latch
    import ulg_pkg::*;
#(
    parameter int NUM_CH = ulg_pkg::CH_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              shut_en,
    input  tmr_evt_t          evt,
    input  logic [NUM_CH-1:0] offend,
    output logic              status,
    output logic [NUM_CH-1:0] mask
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            status <= 1'b0;
            mask   <= '0;
        end else if (evt.expire) begin
            status <= 1'b1;
            if (shut_en) begin
                mask <= mask | offend;
            end
        end
    end

    // R6: a channel can only be latched off together with the status bit
    a_r6_mask_needs_status: assert property (@(posedge clk) disable iff (rst)
        (mask != '0) |-> status);

    // R6: with shutdown disabled the mask does not move
    a_r6_no_shut: assert property (@(posedge clk) disable iff (rst)
        (!shut_en && !clr) |=> $stable(mask));

    // R7: the status bit stays set until cleared
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        (status && !clr) |=> status);

    // R8: a clear strobe empties status and mask
    a_r8_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (!status && mask == '0));

endmodule

// File: rtl/underload_timer.sv
module underload_timer
    import ulg_pkg::*;
#(
    parameter int NUM_CH    = ulg_pkg::CH_DEFAULT,
    parameter int DELAY_CYC = ulg_pkg::DELAY_DEFAULT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] ul_flag,
    input  logic [NUM_CH-1:0] sw_on,
    input  logic              shut_en,
    input  logic              stat_clr,
    output logic              ul_status,
    output logic [NUM_CH-1:0] latch_off
);

    logic [NUM_CH-1:0] offend;
    logic              any_offend;
    tmr_evt_t          evt;

    ulg_qualify #(.NUM_CH(NUM_CH)) u_qual (
        .ul_flag    (ul_flag),
        .sw_on      (sw_on),
        .latched    (latch_off),
        .offend     (offend),
        .any_offend (any_offend)
    );

    ulg_timer #(.DELAY_CYC(DELAY_CYC)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .restart    (stat_clr),
        .any_offend (any_offend),
        .evt        (evt)
    );

    ulg_latch #(.NUM_CH(NUM_CH)) u_latch (
        .clk     (clk),
        .rst     (rst),
        .clr     (stat_clr),
        .shut_en (shut_en),
        .evt     (evt),
        .offend  (offend),
        .status  (ul_status),
        .mask    (latch_off)
    );

    // R9: newly latched channels were flagged and commanded on in the prior cycle
    a_r9_only_offenders: assert property (@(posedge clk) disable iff (rst)
        (!stat_clr) |=> ((latch_off & ~$past(latch_off) & ~$past(ul_flag & sw_on)) == '0));

endmodule

// File: tb/underload_timer_tb_top.sv
module underload_timer_tb_top;

    localparam int NCH = 12;
    localparam int D   = 20;

    logic           clk = 1'b0;
    logic           rst;
    logic [NCH-1:0] ul_flag;
    logic [NCH-1:0] sw_on;
    logic           shut_en;
    logic           stat_clr;
    logic           ul_status;
    logic [NCH-1:0] latch_off;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    underload_timer #(.NUM_CH(NCH), .DELAY_CYC(D)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .ul_flag   (ul_flag),
        .sw_on     (sw_on),
        .shut_en   (shut_en),
        .stat_clr  (stat_clr),
        .ul_status (ul_status),
        .latch_off (latch_off)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic pulse_clr();
        stat_clr = 1'b1;
        step(1);
        stat_clr = 1'b0;
    endtask

    task automatic t_reset();
        check(ul_status == 1'b0, "R1 status", 32'(ul_status), 0);
        check(latch_off == '0, "R1 mask", 32'(latch_off), 0);
    endtask

    task automatic t_basic();
        sw_on   = 12'h001;
        shut_en = 1'b0;
        ul_flag = 12'h001;
        step(D - 1);
        check(ul_status == 1'b0, "R2 early", 32'(ul_status), 0);
        step(1);
        check(ul_status == 1'b1, "R2 expiry", 32'(ul_status), 1);
        check(latch_off == '0, "R6 no shutdown", 32'(latch_off), 0);
        ul_flag = '0;
        step(5);
        check(ul_status == 1'b1, "R7 sticky", 32'(ul_status), 1);
        pulse_clr();
        check(ul_status == 1'b0, "R8 clear", 32'(ul_status), 0);
    endtask

    task automatic t_short();
        sw_on   = 12'h010;
        ul_flag = 12'h010;
        step(D - 2);
        ul_flag = '0;
        step(1);
        ul_flag = 12'h010;
        step(D - 1);
        check(ul_status == 1'b0, "R3 restart early", 32'(ul_status), 0);
        step(1);
        check(ul_status == 1'b1, "R3 full delay", 32'(ul_status), 1);
        ul_flag = '0;
        pulse_clr();
    endtask

    task automatic t_off_chan();
        sw_on   = 12'h001;
        shut_en = 1'b1;
        ul_flag = 12'h002;
        step(2 * D);
        check(ul_status == 1'b0, "R4 off channel status", 32'(ul_status), 0);
        check(latch_off == '0, "R4 off channel mask", 32'(latch_off), 0);
        // the off-channel flag must not have advanced the counter
        ul_flag = 12'h003;
        step(D - 1);
        check(ul_status == 1'b0, "R4 counter untouched", 32'(ul_status), 0);
        step(1);
        check(latch_off == 12'h001, "R4 mask", 32'(latch_off), 32'h001);
        ul_flag = '0;
        pulse_clr();
    endtask

    task automatic t_late_join();
        sw_on   = 12'hFDF;
        shut_en = 1'b1;
        ul_flag = 12'h004;
        step(10);
        ul_flag = 12'h0A4;
        step(D - 11);
        check(latch_off == '0, "R5 before expiry", 32'(latch_off), 0);
        step(1);
        check(latch_off == 12'h084, "R5 late joiner latched", 32'(latch_off), 32'h084);
        check((latch_off & 12'h020) == '0, "R9 off channel excluded", 32'(latch_off), 32'h084);
        check((latch_off & 12'h200) == '0, "R9 quiet channel excluded", 32'(latch_off), 32'h084);
        step(D + 5);
        check(latch_off == 12'h084, "R7 mask held", 32'(latch_off), 32'h084);
        ul_flag = 12'h8A4;
        step(D - 1);
        check(latch_off == 12'h084, "R10 fresh delay early", 32'(latch_off), 32'h084);
        step(1);
        check(latch_off == 12'h884, "R10 new channel latched", 32'(latch_off), 32'h884);
        pulse_clr();
        check(latch_off == '0 && ul_status == 1'b0, "R8 mask cleared", 32'(latch_off), 0);
        step(D - 1);
        check(ul_status == 1'b0, "R8 restart early", 32'(ul_status), 0);
        step(1);
        check(ul_status == 1'b1, "R8 re-reported", 32'(ul_status), 1);
        check(latch_off == 12'h884, "R8 re-latched", 32'(latch_off), 32'h884);
        ul_flag = '0;
        pulse_clr();
    endtask

    initial begin
        rst      = 1'b1;
        ul_flag  = '0;
        sw_on    = '0;
        shut_en  = 1'b0;
        stat_clr = 1'b0;
        step(3);
        rst = 1'b0;
        step(1);
        t_reset();
        t_basic();
        t_short();
        t_off_chan();
        t_late_join();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        #1600000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule